// File: doc/BRIEF.md
# Lockstep Wavefront Sequencer

This block runs one wavefront of 64 work-items on a vector unit that is 16 lanes wide. Each arithmetic instruction is replayed over four back-to-back cycles. Each cycle serves one quarter of the wavefront, and the block presents a quarter index and a 16-bit lane-enable vector to the datapath. All items move through the instruction stream together, and no item starts an instruction before every quarter of the previous one has been issued.

Control flow is handled with an active-item mask and a small stack of saved masks. A branch marker carries one condition bit per item. When the active items disagree on that condition, the taken body runs first with the agreeing items enabled. The else body then runs with the remaining items of the saved mask. A join marker restores the mask that was in force before the branch. When all active items agree, only the chosen body runs and the other body's instructions are consumed without issuing.

The controller has three states:
- S_RUN: idle and ready for an instruction.
- S_REPLAY: issuing quarters 0 to 3.
- S_SKIP: discarding a body that no active item executes.

Transitions:
- S_RUN goes to S_REPLAY on an accepted arithmetic op.
- S_REPLAY stays in S_REPLAY when a new arithmetic op is accepted on quarter 3.
- S_REPLAY goes to S_RUN after quarter 3 when no op is accepted, or when the op accepted on quarter 3 is a marker.
- S_RUN or S_REPLAY goes to S_SKIP on a uniform-false branch, or on an else marker that closes a uniform-true taken body.
- S_SKIP goes back to S_RUN on the else marker or the join marker at nesting level zero.

Top module: `wf_lockstep_seq`

## Requirements
- R1: After reset, in_ready is 1, lane_valid is 0, ovf_err is 0 and all 64 items are active.
- R2: Instruction codes on in_op are 00 arithmetic, 01 branch, 10 else, 11 join. An accepted arithmetic op makes lane_valid high for the next four cycles, with lane_quarter 0, 1, 2, 3 in turn. In quarter q, lane_en bit i equals the active bit of item q*16+i.
- R3: in_ready is 0 during quarters 0 to 2 and 1 during quarter 3. An arithmetic op accepted on quarter 3 continues with quarter 0 in the next cycle, leaving no gap.
- R4: A marker takes one accept cycle and drives no quarter; lane_valid is 0 in the cycle after it.
- R5: A branch on which the active items disagree sets the active mask to active AND cond.
- R6: An else marker after a divergent branch sets the active mask to the saved mask AND NOT the current mask.
- R7: A join marker restores the mask saved by its branch.
- R8: When every active item has cond 1, the mask is unchanged. Arithmetic ops between the matching else and join are accepted but issue no quarter.
- R9: When every active item has cond 0, ops up to the matching else are accepted without issue, including nested branch, else and join markers. The else body then runs with the mask unchanged.
- R10: Branches nest at least four deep, and each join restores its own level's mask.
- R11: A branch pushed onto a full four-entry stack is dropped and sets ovf_err, which stays 1 until reset.
- R12: A quarter whose 16 enables are all zero still occupies its cycle with lane_valid high.
- R13: While a body is skipped, in_ready stays 1 and lane_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_op | input | 2 | Instruction code |
| in_cond | input | 64 | Per-item branch condition |
| in_ready | output | 1 | Instruction accepted this cycle when in_valid is high |
| lane_valid | output | 1 | A quarter is issued this cycle |
| lane_quarter | output | 2 | Index of the issued quarter |
| lane_en | output | 16 | Lane enables for the issued quarter |
| ovf_err | output | 1 | Sticky divergence-stack overflow |

## Verification
Two functions can fall in the same cycle: the final quarter of one instruction and the acceptance of the next one. The bench provokes this by holding in_valid high through a whole replay. It judges the result by requiring quarters 3 and 0 on adjacent cycles, with in_ready high only on quarter 3. Mask updates and skipping are checked by a sweep over 81 per-quarter condition patterns, which covers uniform-true, uniform-false and divergent branches. In each case the resulting mask is read back through the lane enables of a following arithmetic op.

// File: rtl/wfseq_pkg.sv
package wfseq_pkg;
    typedef enum logic [1:0] {
        OP_ALU    = 2'b00,
        OP_BRANCH = 2'b01,
        OP_ELSE   = 2'b10,
        OP_JOIN   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        S_RUN    = 2'b00,
        S_REPLAY = 2'b01,
        S_SKIP   = 2'b10
    } seq_state_e;
endpackage

// File: rtl/wf_div_stack.sv
module wf_div_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 66
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         ovf
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;
    logic          full;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign top   = empty ? '0 : mem[AW'(cnt - CW'(1))];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (push) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                mem[AW'(cnt)] <= push_data;
                cnt           <= cnt + CW'(1);
            end
        end else if (pop && !empty) begin
            cnt <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/wf_lane_slice.sv
module wf_lane_slice #(
    parameter int WAVE  = 64,
    parameter int LANES = 16,
    parameter int QW    = 2
) (
    input  logic [WAVE-1:0]  mask,
    input  logic [QW-1:0]    sel,
    output logic [LANES-1:0] lanes
);
    localparam int NQ = WAVE / LANES;

    logic [LANES-1:0] slice [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_quarter
        assign slice[g] = mask[g*LANES +: LANES];
    end

    assign lanes = slice[sel];
endmodule

// File: rtl/wf_lockstep_seq.sv
module wf_lockstep_seq
    import wfseq_pkg::*;
#(
    parameter int WAVE   = 64,
    parameter int LANES  = 16,
    parameter int DEPTH  = 4,
    parameter int NEST_W = 4,
    localparam int QW    = $clog2(WAVE / LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [WAVE-1:0]  in_cond,
    output logic             in_ready,
    output logic             lane_valid,
    output logic [QW-1:0]    lane_quarter,
    output logic [LANES-1:0] lane_en,
    output logic             ovf_err
);
    localparam int QUARTERS = WAVE / LANES;
    localparam int EW       = WAVE + 2;
    localparam logic [QW-1:0] LAST_Q = QW'(QUARTERS - 1);

    seq_state_e      state, n_state;
    logic [QW-1:0]   q, n_q;
    logic [WAVE-1:0] active, n_act;
    logic [NEST_W-1:0] nest, n_nest;

    logic          take, push, pop, st_empty;
    logic [EW-1:0] push_d, top;
    logic [WAVE-1:0] top_mask, t_set, f_set;
    logic          top_taken, top_uni;
    logic [LANES-1:0] slice_out;
    op_e           op;

    assign op        = op_e'(in_op);
    assign top_mask  = top[WAVE-1:0];
    assign top_taken = top[WAVE];
    assign top_uni   = top[WAVE+1];
    assign t_set     = active & in_cond;
    assign f_set     = active & ~in_cond;
    assign take      = in_valid && in_ready;

    wf_div_stack #(.DEPTH(DEPTH), .W(EW)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_data(push_d), .top(top), .empty(st_empty), .ovf(ovf_err)
    );

    wf_lane_slice #(.WAVE(WAVE), .LANES(LANES), .QW(QW)) u_slice (
        .mask(active), .sel(q), .lanes(slice_out)
    );

    // next-state logic
    always_comb begin
        n_state = state;
        n_q     = q;
        n_act   = active;
        n_nest  = nest;
        push    = 1'b0;
        pop     = 1'b0;
        push_d  = '0;
        unique case (state)
            S_REPLAY: begin
                if (q != LAST_Q)  n_q = q + QW'(1);
                else if (!take)   n_state = S_RUN;
            end
            S_RUN, S_SKIP: ;
            default: n_state = S_RUN;
        endcase
        if (take) begin
            if (state == S_SKIP) begin
                unique case (op)
                    OP_ALU:    ;
                    OP_BRANCH: n_nest = nest + NEST_W'(1);
                    OP_ELSE:   if (nest == '0 && !top_taken) n_state = S_RUN;
                    OP_JOIN: begin
                        if (nest == '0) begin
                            pop     = 1'b1;
                            n_act   = top_mask;
                            n_state = S_RUN;
                        end else begin
                            n_nest = nest - NEST_W'(1);
                        end
                    end
                endcase
            end else begin
                n_state = S_RUN;
                unique case (op)
                    OP_ALU: begin
                        n_state = S_REPLAY;
                        n_q     = '0;
                    end
                    OP_BRANCH: begin
                        push = 1'b1;
                        if (|t_set && |f_set) begin
                            push_d = {1'b0, 1'b1, active};
                            n_act  = t_set;
                        end else if (|t_set) begin
                            push_d = {1'b1, 1'b1, active};
                        end else begin
                            push_d  = {1'b1, 1'b0, active};
                            n_state = S_SKIP;
                            n_nest  = '0;
                        end
                    end
                    OP_ELSE: begin
                        if (!st_empty) begin
                            if (!top_uni) begin
                                n_act = top_mask & ~active;
                            end else if (top_taken) begin
                                n_state = S_SKIP;
                                n_nest  = '0;
                            end
                        end
                    end
                    OP_JOIN: begin
                        if (!st_empty) begin
                            pop   = 1'b1;
                            n_act = top_mask;
                        end
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_RUN;
            q      <= '0;
            active <= '1;
            nest   <= '0;
        end else begin
            state  <= n_state;
            q      <= n_q;
            active <= n_act;
            nest   <= n_nest;
        end
    end

    // outputs
    always_comb begin
        lane_valid   = (state == S_REPLAY);
        in_ready     = (state != S_REPLAY) || (q == LAST_Q);
        lane_quarter = q;
        lane_en      = lane_valid ? slice_out : '0;
    end
endmodule

// File: rtl/wf_lockstep_seq_chk.sv
module wf_lockstep_seq_chk #(
    parameter int QW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          lane_valid,
    input logic [QW-1:0] lane_quarter,
    input logic          ovf_err
);
    localparam logic [QW-1:0] LAST = '1;

    // R2
    quarter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid && lane_quarter != LAST) |=>
            (lane_valid && lane_quarter == $past(lane_quarter) + QW'(1)));

    // R2
    first_quarter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_valid) |-> (lane_quarter == '0));

    // R3
    no_midissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid && lane_quarter != LAST) |-> !in_ready);

    // R3
    tail_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid && lane_quarter == LAST) |-> in_ready);

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
endmodule

bind wf_lockstep_seq wf_lockstep_seq_chk #(.QW(QW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .lane_valid(lane_valid),
    .lane_quarter(lane_quarter), .ovf_err(ovf_err)
);

// File: tb/wf_lockstep_seq_tb.sv
module wf_lockstep_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [63:0] in_cond = '0;
    logic        in_ready, lane_valid, ovf_err;
    logic [1:0]  lane_quarter;
    logic [15:0] lane_en;
    int errs = 0;
    int checks = 0;

    localparam logic [1:0] ALU = 2'b00, BR = 2'b01, ELS = 2'b10, JN = 2'b11;

    always #5 clk = ~clk;

    wf_lockstep_seq u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_cond(in_cond), .in_ready(in_ready), .lane_valid(lane_valid),
        .lane_quarter(lane_quarter), .lane_en(lane_en), .ovf_err(ovf_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [1:0] op, input logic [63:0] c);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_op = op;
        in_cond = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic capture(input string req, output logic [63:0] m);
        m = '0;
        send(ALU, '0);
        for (int q = 0; q < 4; q++) begin
            if (q > 0) @(negedge clk);
            chk({req, " R2 R12 quarter issue"}, 64'({lane_valid, lane_quarter}), 64'({1'b1, 2'(q)}));
            m[q*16 +: 16] = lane_en;
        end
    endtask

    task automatic skipped_alu(input string req);
        send(ALU, '0);
        chk({req, " R13 skipped op"}, 64'({in_ready, lane_valid}), 64'(2'b10));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [63:0] m;
        logic [63:0] a1, a2, a3, a4;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", 64'({in_ready, lane_valid, ovf_err}), 64'(3'b100));
        capture("R1", m);
        chk("R1 full mask", m, '1);

        // R3 back-to-back ops, no gap
        @(negedge clk);
        in_valid = 1'b1;
        in_op = ALU;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k == 4) in_valid = 1'b0;
            chk("R3 gapless quarter", 64'({lane_valid, lane_quarter}), 64'({1'b1, 2'(k % 4)}));
            chk("R3 ready pattern", 64'(in_ready), 64'((k % 4) == 3));
        end

        // sweep over per-quarter condition patterns
        for (int k = 0; k < 81; k++) begin
            automatic logic [63:0] c = '0;
            automatic int r = k;
            for (int q = 0; q < 4; q++) begin
                automatic int code = r % 3;
                r = r / 3;
                c[q*16 +: 16] = (code == 0) ? 16'h0000 :
                                (code == 1) ? 16'hFFFF : (16'h5A5A ^ 16'(q * 16'h1111));
            end
            send(BR, c);
            chk("R4 marker no issue", 64'(lane_valid), 64'(0));
            if (c == '1) begin
                capture("R8 taken", m);
                chk("R8 uniform true mask", m, '1);
                send(ELS, '0);
                skipped_alu("R8");
                send(JN, '0);
                capture("R8 after join", m);
                chk("R8 join mask", m, '1);
            end else if (c == '0) begin
                skipped_alu("R9");
                send(ELS, '0);
                capture("R9 else body", m);
                chk("R9 else mask", m, '1);
                send(JN, '0);
                capture("R9 after join", m);
                chk("R9 join mask", m, '1);
            end else begin
                capture("R5", m);
                chk("R5 taken mask", m, c);
                send(ELS, '0);
                capture("R6", m);
                chk("R6 else mask", m, ~c);
                send(JN, '0);
                capture("R7", m);
                chk("R7 join mask", m, '1);
            end
        end

        // R9 nested markers inside a skipped body
        send(BR, '0);
        send(BR, 64'hFFFF);
        send(ELS, '0);
        skipped_alu("R9 nested");
        send(JN, '0);
        skipped_alu("R9 after inner join");
        send(ELS, '0);
        capture("R9 outer else", m);
        chk("R9 outer else mask", m, '1);
        send(JN, '0);

        // R10 four-deep nesting, R12 empty quarters
        a1 = 64'h0000_0000_FFFF_FFFF;
        a2 = a1 & 64'h5555_5555_5555_5555;
        a3 = a2 & 64'h0000_0000_0000_0F0F;
        a4 = a3 & 64'h0000_0000_0000_0003;
        send(BR, 64'h0000_0000_FFFF_FFFF);
        capture("R10 l1", m); chk("R10 level1", m, a1);
        send(BR, 64'h5555_5555_5555_5555);
        capture("R10 l2", m); chk("R10 level2", m, a2);
        send(BR, 64'h0000_0000_0000_0F0F);
        capture("R12 l3", m); chk("R12 level3 empty quarters", m, a3);
        send(BR, 64'h0000_0000_0000_0003);
        capture("R10 l4", m); chk("R10 level4", m, a4);
        chk("R11 no overflow at depth4", 64'(ovf_err), 64'(0));
        send(JN, '0); capture("R10 j4", m); chk("R10 join4", m, a3);
        send(JN, '0); capture("R10 j3", m); chk("R10 join3", m, a2);
        send(JN, '0); capture("R10 j2", m); chk("R10 join2", m, a1);
        send(JN, '0); capture("R10 j1", m); chk("R10 join1", m, '1);

        // R11 overflow on fifth push
        send(BR, 64'h0000_0000_FFFF_FFFF);
        send(BR, 64'h0000_0000_0000_FFFF);
        send(BR, 64'h0000_0000_0000_00FF);
        send(BR, 64'h0000_0000_0000_000F);
        chk("R11 flag clear when full", 64'(ovf_err), 64'(0));
        send(BR, 64'h0000_0000_0000_0003);
        chk("R11 overflow set", 64'(ovf_err), 64'(1));
        capture("R11 mask", m);
        chk("R11 mask after dropped push", m, 64'h3);
        send(JN, '0);
        capture("R11 pop", m);
        chk("R11 pop returns level4 save", m, 64'hFF);
        chk("R11 sticky", 64'(ovf_err), 64'(1));

        do_reset();
        @(negedge clk);
        chk("R1 reset clears overflow", 64'({in_ready, lane_valid, ovf_err}), 64'(3'b100));
        capture("R1 after reset", m);
        chk("R1 mask after reset", m, '1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule